// File: doc/BRIEF.md
# Field CRC Generator and Checker

This block works out two 16-bit check words over each video field: one over the active picture and one over the full field. Each is a CRC with the generator x^16 + x^12 + x^5 + 1. Video words arrive one per clock. Two separate enable windows decide which words feed each CRC. The window positions for each video standard are worked out elsewhere and arrive as inputs. An end-of-field strobe latches both results, which then stay readable for the whole of the next field.

The received check words are supplied on the same strobe. In receive mode each calculated word is compared with its received word, and any difference raises a mismatch flag. In transmit mode the flags stay clear. In both modes the calculated values feed a packet-word formatter. Given a word index, the formatter returns the packet header constants, the six CRC payload words or one of seven reserved words. Each returned word has parity and the complement bit already filled in.

Words 3FCh through 3FFh are treated as 3FFh before they enter either CRC. This keeps 8-bit and 10-bit sources in agreement.

Top module: `edh_field_crc`

## Requirements
- R1: Each CRC starts from zero at the first enabled word of its window. For every enabled word it shifts in the 10 data bits LSB first. For each bit, feedback = bit XOR crc[0], the register shifts right by one, and it is XORed with 8408h when feedback is 1. Words with the enable low leave it unchanged.
- R2: Any input word from 3FCh to 3FFh gives the same CRC as 3FFh.
- R3: On the clock edge where field_end is high, the running values (including any word enabled in that cycle) are copied to ap_crc and ff_crc. Both outputs hold at every other edge, and both are zero after reset.
- R4: At a field_end edge with tx_mode low, ap_err and ff_err become 1 exactly when the newly latched CRC differs from rx_ap_crc or rx_ff_crc (sampled in that cycle). The flags hold until the next field_end.
- R5: At a field_end edge with tx_mode high, both mismatch flags become 0, whatever the received words are.
- R6: The two CRCs are independent. A word inside only one window changes only that CRC.
- R7: Packet index 3, 4 and 5 give the active-picture CRC and 6, 7 and 8 give the full-field CRC. The first word carries crc[5:0] in bits 7:2 and the second carries crc[11:6]. The third carries crc[15:12] in bits 5:2, 0 in bit 6, and the CRC-valid bit in bit 7. The valid bit is 1 once any field_end has occurred since reset.
- R8: Index 9+k (k=0..6) returns reserved word k+1, whose user bits are rsv_bits[6k+5:6k] placed in bits 7:2.
- R9: Every word from index 3 to 15 has bits 1:0 = 0, bit 8 = even parity over bits 7:2, and bit 9 = NOT bit 8.
- R10: Index 0 gives 1F4h, index 1 gives 200h and index 2 gives 110h. Indices from 16 up return 000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 10 | Video word |
| ap_en | input | 1 | Active-picture window enable |
| ff_en | input | 1 | Full-field window enable |
| field_end | input | 1 | End-of-field strobe |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| rx_ap_crc | input | 16 | Received active-picture CRC |
| rx_ff_crc | input | 16 | Received full-field CRC |
| rsv_bits | input | 42 | User bits of reserved words 1..7, six each |
| pkt_idx | input | 5 | Packet word index |
| ap_crc | output | 16 | Latched active-picture CRC |
| ff_crc | output | 16 | Latched full-field CRC |
| ap_err | output | 1 | Active-picture mismatch flag |
| ff_err | output | 1 | Full-field mismatch flag |
| pkt_word | output | 10 | Formatted packet word |

## Verification
Random fields use random lengths and random window placements, so different word subsets feed the two CRCs. These fields show whether the windows are kept apart and whether the preset happens at each window start. Some fields are rich in words from 3FCh to 3FFh. These show whether the recode is applied, and a directed pair of all-3FCh and all-3FFh fields must give the same CRC. Received words are either correct or have a single bit flipped, under both modes, which separates a real comparison from a stuck flag. The tx case shows that the flags are forced clear. An all-zero field and a field with the window held high through the strobe cover the boundary cases of the preset and the latch.

// File: rtl/edh_crc_pkg.sv
package edh_crc_pkg;

    localparam int WORD_W  = 10;
    localparam int CRC_W   = 16;
    localparam int USR_W   = 6;
    localparam int IDX_W   = 5;
    localparam logic [CRC_W-1:0]  CRC_FB   = 16'h8408;
    localparam logic [WORD_W-1:0] REC_LO   = 10'h3FC;
    localparam logic [WORD_W-1:0] REC_VAL  = 10'h3FF;
    localparam logic [WORD_W-1:0] HDR_ID   = 10'h1F4;
    localparam logic [WORD_W-1:0] HDR_BLK  = 10'h200;
    localparam logic [WORD_W-1:0] HDR_CNT  = 10'h110;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [USR_W-1:0]  usr_t;

    typedef struct packed {
        logic       inv;
        logic       par;
        usr_t       usr;
        logic [1:0] pad;
    } pkt_word_t;

    function automatic word_t recode(input word_t w);
        return (w >= REC_LO) ? REC_VAL : w;
    endfunction

    function automatic crc_t crc_word(input crc_t c, input word_t w);
        crc_t r;
        r = c;
        for (int b = 0; b < WORD_W; b++) begin
            if (r[0] ^ w[b]) r = (r >> 1) ^ CRC_FB;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic pkt_word_t pack_usr(input usr_t u);
        pkt_word_t p;
        p.pad = 2'b00;
        p.usr = u;
        p.par = ^u;
        p.inv = ~(^u);
        return p;
    endfunction

endpackage

// File: rtl/edh_crc_lane.sv
module edh_crc_lane
    import edh_crc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  win_en,
    input  logic  field_end,
    input  word_t word,
    output crc_t  crc_end,
    output crc_t  crc_q
);
    crc_t run_q;
    logic open_q;
    crc_t seed;

    always_comb begin
        seed    = open_q ? run_q : '0;
        crc_end = win_en ? crc_word(seed, word) : run_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            open_q <= 1'b0;
            crc_q  <= '0;
        end else if (field_end) begin
            run_q  <= '0;
            open_q <= 1'b0;
            crc_q  <= crc_end;
        end else begin
            run_q  <= crc_end;
            open_q <= win_en;
        end
    end
endmodule

// File: rtl/edh_crc_cmp.sv
module edh_crc_cmp
    import edh_crc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic field_end,
    input  logic tx_mode,
    input  crc_t calc,
    input  crc_t rcvd,
    output logic err_q
);
    always_ff @(posedge clk) begin
        if (rst)            err_q <= 1'b0;
        else if (field_end) err_q <= !tx_mode && (calc != rcvd);
    end
endmodule

// File: rtl/edh_pkt_fmt.sv
module edh_pkt_fmt
    import edh_crc_pkg::*;
#(
    parameter int RSV_N = 7
) (
    input  logic [IDX_W-1:0]       idx,
    input  crc_t                   ap_crc,
    input  crc_t                   ff_crc,
    input  logic                   valid,
    input  logic [RSV_N*USR_W-1:0] rsv_bits,
    output word_t                  word
);
    localparam int CRC_BASE = 3;
    localparam int RSV_BASE = CRC_BASE + 6;
    localparam int TOP_IDX  = RSV_BASE + RSV_N;

    usr_t crc_usr [6];

    always_comb begin
        crc_usr[0] = ap_crc[5:0];
        crc_usr[1] = ap_crc[11:6];
        crc_usr[2] = {valid, 1'b0, ap_crc[15:12]};
        crc_usr[3] = ff_crc[5:0];
        crc_usr[4] = ff_crc[11:6];
        crc_usr[5] = {valid, 1'b0, ff_crc[15:12]};
    end

    always_comb begin
        word = '0;
        if (int'(idx) == 0)      word = HDR_ID;
        else if (int'(idx) == 1) word = HDR_BLK;
        else if (int'(idx) == 2) word = HDR_CNT;
        else if (int'(idx) < RSV_BASE)
            word = pack_usr(crc_usr[int'(idx) - CRC_BASE]);
        else if (int'(idx) < TOP_IDX)
            word = pack_usr(rsv_bits[(int'(idx) - RSV_BASE)*USR_W +: USR_W]);
    end
endmodule

// File: rtl/edh_field_crc.sv
module edh_field_crc
    import edh_crc_pkg::*;
#(
    parameter int RSV_N = 7
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [9:0]             din,
    input  logic                   ap_en,
    input  logic                   ff_en,
    input  logic                   field_end,
    input  logic                   tx_mode,
    input  logic [15:0]            rx_ap_crc,
    input  logic [15:0]            rx_ff_crc,
    input  logic [RSV_N*6-1:0]     rsv_bits,
    input  logic [4:0]             pkt_idx,
    output logic [15:0]            ap_crc,
    output logic [15:0]            ff_crc,
    output logic                   ap_err,
    output logic                   ff_err,
    output logic [9:0]             pkt_word
);
    localparam int LANES = 2;

    word_t w_rec;
    logic  en_v   [LANES];
    crc_t  rx_v   [LANES];
    crc_t  end_v  [LANES];
    crc_t  crc_v  [LANES];
    logic  err_v  [LANES];
    logic  valid_q;

    assign w_rec = recode(din);
    assign en_v[0] = ap_en;
    assign en_v[1] = ff_en;
    assign rx_v[0] = rx_ap_crc;
    assign rx_v[1] = rx_ff_crc;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        edh_crc_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .win_en   (en_v[g]),
            .field_end(field_end),
            .word     (w_rec),
            .crc_end  (end_v[g]),
            .crc_q    (crc_v[g])
        );
        edh_crc_cmp u_cmp (
            .clk      (clk),
            .rst      (rst),
            .field_end(field_end),
            .tx_mode  (tx_mode),
            .calc     (end_v[g]),
            .rcvd     (rx_v[g]),
            .err_q    (err_v[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)            valid_q <= 1'b0;
        else if (field_end) valid_q <= 1'b1;
    end

    edh_pkt_fmt #(.RSV_N(RSV_N)) u_fmt (
        .idx     (pkt_idx),
        .ap_crc  (crc_v[0]),
        .ff_crc  (crc_v[1]),
        .valid   (valid_q),
        .rsv_bits(rsv_bits),
        .word    (pkt_word)
    );

    assign ap_crc = crc_v[0];
    assign ff_crc = crc_v[1];
    assign ap_err = err_v[0];
    assign ff_err = err_v[1];
endmodule

// File: rtl/edh_field_crc_chk.sv
module edh_field_crc_chk (
    input logic        clk,
    input logic        rst,
    input logic        field_end,
    input logic        tx_mode,
    input logic [15:0] rx_ap_crc,
    input logic [15:0] rx_ff_crc,
    input logic [4:0]  pkt_idx,
    input logic [15:0] ap_crc,
    input logic [15:0] ff_crc,
    input logic        ap_err,
    input logic        ff_err,
    input logic [9:0]  pkt_word
);
    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !field_end |=> ($stable(ap_crc) && $stable(ff_crc))); // R3

    AST_RX_COMPARE: assert property (@(posedge clk) disable iff (rst)
        (field_end && !tx_mode) |=>
            ((ap_err == (ap_crc != $past(rx_ap_crc))) &&
             (ff_err == (ff_crc != $past(rx_ff_crc))))); // R4

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !field_end |=> ($stable(ap_err) && $stable(ff_err))); // R4

    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (field_end && tx_mode) |=> (!ap_err && !ff_err)); // R5

    AST_WORD_PARITY: assert property (@(posedge clk) disable iff (rst)
        (pkt_idx >= 5'd3 && pkt_idx <= 5'd15) |->
            (pkt_word[1:0] == 2'b00 && (^pkt_word[8:2]) == 1'b0 &&
             pkt_word[9] != pkt_word[8])); // R9

    AST_HEADER_ID: assert property (@(posedge clk) disable iff (rst)
        (pkt_idx == 5'd0) |-> (pkt_word == 10'h1F4)); // R10
endmodule

bind edh_field_crc edh_field_crc_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .field_end(field_end),
    .tx_mode  (tx_mode),
    .rx_ap_crc(rx_ap_crc),
    .rx_ff_crc(rx_ff_crc),
    .pkt_idx  (pkt_idx),
    .ap_crc   (ap_crc),
    .ff_crc   (ff_crc),
    .ap_err   (ap_err),
    .ff_err   (ff_err),
    .pkt_word (pkt_word)
);

// File: tb/test_edh_field_crc.sv
module test_edh_field_crc;
    logic        clk = 1'b0;
    logic        rst;
    logic [9:0]  din;
    logic        ap_en, ff_en, field_end, tx_mode;
    logic [15:0] rx_ap_crc, rx_ff_crc;
    logic [41:0] rsv_bits;
    logic [4:0]  pkt_idx;
    logic [15:0] ap_crc, ff_crc;
    logic        ap_err, ff_err;
    logic [9:0]  pkt_word;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    edh_field_crc i_edh_field_crc (
        .clk(clk), .rst(rst), .din(din), .ap_en(ap_en), .ff_en(ff_en),
        .field_end(field_end), .tx_mode(tx_mode), .rx_ap_crc(rx_ap_crc),
        .rx_ff_crc(rx_ff_crc), .rsv_bits(rsv_bits), .pkt_idx(pkt_idx),
        .ap_crc(ap_crc), .ff_crc(ff_crc), .ap_err(ap_err), .ff_err(ff_err),
        .pkt_word(pkt_word)
    );

    function automatic logic [15:0] m_step(input logic [15:0] c, input logic [9:0] w);
        logic [9:0]  v;
        logic [15:0] r;
        v = (w >= 10'h3FC) ? 10'h3FF : w;
        r = c;
        for (int i = 0; i < 10; i++) begin
            logic fb;
            fb = r[0] ^ v[i];
            r = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    function automatic logic [9:0] m_fmt(input logic [5:0] u);
        return {~(^u), ^u, u, 2'b00};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [15:0] last_ap, last_ff;

    // One field: words, windows [a_lo,a_hi] and [f_lo,f_hi], strobe afterwards
    task automatic run_field(input int len, input int a_lo, input int a_hi,
                             input int f_lo, input int f_hi, input int mode,
                             input bit tx, input bit bad_ap, input bit bad_ff,
                             input bit hold_ff);
        logic [15:0] eap, eff;
        logic [9:0]  w;
        eap = 16'h0;
        eff = 16'h0;
        tx_mode = tx;
        for (int i = 0; i < len; i++) begin
            case (mode)
                0: w = 10'($urandom);
                1: w = (($urandom % 2) != 0) ? 10'(10'h3FC + ($urandom % 4)) : 10'($urandom);
                2: w = 10'h000;
                3: w = 10'h3FC;
                default: w = 10'h3FF;
            endcase
            @(negedge clk);
            din   = w;
            ap_en = (i >= a_lo && i <= a_hi);
            ff_en = (i >= f_lo && i <= f_hi);
            if (ap_en) eap = m_step(eap, w);
            if (ff_en) eff = m_step(eff, w);
        end
        @(negedge clk);
        din   = 10'($urandom);
        ap_en = 1'b0;
        ff_en = hold_ff;
        if (hold_ff) eff = m_step(eff, din);
        field_end = 1'b1;
        rx_ap_crc = bad_ap ? (eap ^ (16'h1 << ($urandom % 16))) : eap;
        rx_ff_crc = bad_ff ? (eff ^ (16'h1 << ($urandom % 16))) : eff;
        @(negedge clk);
        field_end = 1'b0;
        ff_en     = 1'b0;
        check("R1 R6 ap_crc", ap_crc, eap);
        check(hold_ff ? "R3 ff_crc latch with window open" : "R1 R6 ff_crc", ff_crc, eff);
        check(tx ? "R5 ap_err" : "R4 ap_err", {15'h0, ap_err}, {15'h0, !tx && bad_ap});
        check(tx ? "R5 ff_err" : "R4 ff_err", {15'h0, ff_err}, {15'h0, !tx && bad_ff});
        // R7 packet CRC words
        pkt_idx = 5'd3; #0.5 check("R7 ap word a", {6'h0, pkt_word}, {6'h0, m_fmt(eap[5:0])});
        pkt_idx = 5'd4; #0.5 check("R7 ap word b", {6'h0, pkt_word}, {6'h0, m_fmt(eap[11:6])});
        pkt_idx = 5'd5; #0.5 check("R7 R9 ap word c", {6'h0, pkt_word}, {6'h0, m_fmt({2'b10, eap[15:12]})});
        pkt_idx = 5'd6; #0.5 check("R7 ff word a", {6'h0, pkt_word}, {6'h0, m_fmt(eff[5:0])});
        pkt_idx = 5'd7; #0.5 check("R7 ff word b", {6'h0, pkt_word}, {6'h0, m_fmt(eff[11:6])});
        pkt_idx = 5'd8; #0.5 check("R7 R9 ff word c", {6'h0, pkt_word}, {6'h0, m_fmt({2'b10, eff[15:12]})});
        // R3 hold for a few idle cycles
        repeat (3) @(negedge clk);
        check("R3 ap_crc hold", ap_crc, eap);
        check("R3 ff_crc hold", ff_crc, eff);
        last_ap = eap;
        last_ff = eff;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] keep;
        void'($urandom(32'd1234));
        rst = 1'b1; din = '0; ap_en = 0; ff_en = 0; field_end = 0; tx_mode = 0;
        rx_ap_crc = '0; rx_ff_crc = '0; rsv_bits = '0; pkt_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R3 reset ap_crc", ap_crc, 16'h0);
        check("R3 reset ff_crc", ff_crc, 16'h0);
        check("R4 reset flags", {14'h0, ap_err, ff_err}, 16'h0);
        pkt_idx = 5'd5; #0.5
        check("R7 valid bit clear after reset", {6'h0, pkt_word}, 16'h0200);

        // R10 header constants and out-of-range indices
        pkt_idx = 5'd0;  #0.5 check("R10 id word", {6'h0, pkt_word}, 16'h01F4);
        pkt_idx = 5'd1;  #0.5 check("R10 block word", {6'h0, pkt_word}, 16'h0200);
        pkt_idx = 5'd2;  #0.5 check("R10 count word", {6'h0, pkt_word}, 16'h0110);
        pkt_idx = 5'd16; #0.5 check("R10 beyond range", {6'h0, pkt_word}, 16'h0000);
        pkt_idx = 5'd31; #0.5 check("R10 top index", {6'h0, pkt_word}, 16'h0000);

        // R8 R9 reserved words with random user bits
        for (int t = 0; t < 4; t++) begin
            rsv_bits = {10'($urandom), 32'($urandom)};
            for (int k = 0; k < 7; k++) begin
                pkt_idx = 5'(9 + k); #0.5
                check("R8 R9 reserved word", {6'h0, pkt_word}, {6'h0, m_fmt(rsv_bits[6*k +: 6])});
            end
        end

        // Directed: all-zero window keeps CRC at zero (R1)
        run_field(20, 2, 10, 1, 18, 2, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1 zero data gives zero", ap_crc, 16'h0);
        // Directed: 3FC versus 3FF give the same CRC (R2)
        run_field(16, 1, 12, 0, 15, 3, 1'b0, 1'b1, 1'b0, 1'b0);
        keep = ap_crc;
        run_field(16, 1, 12, 0, 15, 4, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R2 3FC equals 3FF", ap_crc, keep);
        // Directed: transmit with corrupted received words (R5)
        run_field(24, 4, 9, 2, 20, 0, 1'b1, 1'b1, 1'b1, 1'b0);
        // Directed: full-field window open through the strobe (R3)
        run_field(18, 3, 6, 5, 17, 0, 1'b0, 1'b0, 1'b0, 1'b1);

        // Random fields
        for (int f = 0; f < 40; f++) begin
            int len, alo, ahi, flo, fhi;
            len = 10 + int'($urandom % 50);
            flo = int'($urandom % 3);
            fhi = len - 1 - int'($urandom % 3);
            alo = flo + int'($urandom % ((fhi - flo) / 2 + 1));
            ahi = alo + int'($urandom % (fhi - alo + 1));
            run_field(len, alo, ahi, flo, fhi, int'($urandom % 2),
                      1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule